// File: doc/BRIEF.md
# DMA burst length and event calculator

This block sits beside a DMA channel's transfer engine and decides how far the engine may run in one go. The engine presents the channel's current position, its element, frame and packet counters, together with the lengths, address deltas, synchronisation mode and interrupt enables. The block returns how many elements can be moved before some condition needs attention, and which conditions land exactly on the end of that burst. It also returns the counters and both addresses as they stand after the burst, so the engine can write them back in one step. It does not move any data.

Each possible stopping condition produces a distance in elements, measured from the current position. A condition that is switched off gets the largest value the distance field can hold. The burst length is the smallest distance. Every condition whose distance equals that smallest value is reported at once. The block also sorts each side's access pattern into constant, linear or other, which tells a faster copy path whether it may take over.

A request is presented with a one-cycle `start` strobe. All results are registered and appear with `done` on the following cycle. They hold until the next strobe.

Top module: `dma_burst_calc`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `burst_elems`, `burst_bytes` and `events` are zero until the first `start`.
- R2: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise. The results present with `done` belong to that request.
- R3: `burst_elems` is the smallest distance over all enabled conditions. End of block is always enabled, with distance (frames − frame − 1)·elements + (elements − element).
- R4: An element-synchronised channel (`sync_en` high, `frame_mode` low, `packet_mode` low) has an element-sync distance of 1. A frame-synchronised channel (`sync_en` and `frame_mode` high) has an end-of-frame distance of elements − element, gated by `ie_frame`. When `packet_mode` is also low, the same channel has a frame-sync distance of elements − element.
- R5: The last-frame distance (frames − frame − 2)·elements + (elements − element + 1) counts only when `ie_last` is high and either frame < frames − 1 or element = 0. The half-frame distance counts only when `ie_half` is high. It is elements/2 (rounded down) − element, plus elements when element ≥ elements/2.
- R6: With `frame_mode` and `packet_mode` both high, two distances of packet length − packet counter apply. The packet-sync one needs `sync_en`. The packet-interrupt one needs `ie_pkt` and low `src_sync`.
- R7: `events` bit i is high exactly when condition i is enabled and its distance equals `burst_elems`. The bits are: 0 element sync, 1 last frame, 2 half frame, 3 end of frame, 4 frame sync, 5 packet, 6 packet sync, 7 end of block.
- R8: With t = element + n, `next_elem` = t mod elements and `next_frame` = frame + t div elements. `next_pkt` = (packet + n) mod packet length when both `frame_mode` and `packet_mode` are high; otherwise it equals the input packet counter.
- R9: Each of `next_src` and `next_dst` equals its address + n·element delta + (t div elements)·frame delta, modulo 2^ADDR_W, with deltas in two's complement.
- R10: `burst_bytes` = `burst_elems` · `elem_size`.
- R11: Each side's class is 0 (constant) when its element delta is 0, and 1 (linear) when its element delta equals `elem_size`. Both need `fill_en`, `xpar_en` and `endian_mis` all low, and either `frm_len` = 1 or that side's frame delta = 0. Any other case is 2 (other).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; inputs are sampled in this cycle |
| elem_len | input | CNT_W | Elements per frame (≥ 1) |
| frm_len | input | FRM_W | Frames per block (≥ 1) |
| pkt_len | input | PKT_W | Elements per packet (≥ 1) |
| elem_pos | input | CNT_W | Current element counter (< elem_len) |
| frm_pos | input | FRM_W | Current frame counter (< frm_len) |
| pkt_pos | input | PKT_W | Current packet counter (< pkt_len) |
| sync_en | input | 1 | Channel is hardware synchronised |
| frame_mode | input | 1 | Frame granularity selected |
| packet_mode | input | 1 | Packet granularity selected |
| src_sync | input | 1 | Synchronisation is on the source side |
| ie_last | input | 1 | Last-frame interrupt enable |
| ie_half | input | 1 | Half-frame interrupt enable |
| ie_frame | input | 1 | End-of-frame interrupt enable |
| ie_pkt | input | 1 | End-of-packet interrupt enable |
| elem_size | input | 3 | Element size in bytes (1, 2 or 4) |
| src_addr | input | ADDR_W | Current source address |
| dst_addr | input | ADDR_W | Current destination address |
| src_edelta | input | ADDR_W | Source element delta |
| src_fdelta | input | ADDR_W | Source frame delta |
| dst_edelta | input | ADDR_W | Destination element delta |
| dst_fdelta | input | ADDR_W | Destination frame delta |
| fill_en | input | 1 | Constant fill selected |
| xpar_en | input | 1 | Transparent copy selected |
| endian_mis | input | 1 | Source and destination byte orders differ |
| done | output | 1 | Results valid |
| burst_elems | output | DIST_W | Elements in this burst |
| burst_bytes | output | DIST_W+3 | Bytes in this burst |
| events | output | 8 | Conditions reached at burst end |
| next_elem | output | CNT_W | Element counter after the burst |
| next_frame | output | FRM_W | Frame counter after the burst |
| next_pkt | output | PKT_W | Packet counter after the burst |
| next_src | output | ADDR_W | Source address after the burst |
| next_dst | output | ADDR_W | Destination address after the burst |
| src_class | output | 2 | Source access class |
| dst_class | output | 2 | Destination access class |

## Verification
The main sweep covers every position in blocks of one to five elements per frame and one to three frames. Each position is tried under all 256 combinations of the four mode bits and four interrupt enables. The one-element frames and the first and last positions separate the half-frame wrap from the last-frame guard at element 0. Single-frame blocks show where the last-frame distance would turn negative if its guard were missing. Varying the element size and using a frame delta that wraps the address show whether bytes and addresses are scaled and wrapped correctly. A second sweep covers each access-class input alone and in combination, so any single term dropped from the constant or linear test changes a class.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [1:0] {
    ACC_CONST  = 2'd0,
    ACC_LINEAR = 2'd1,
    ACC_OTHER  = 2'd2
  } acc_class_e;

  localparam int NUM_EV       = 8;
  localparam int EV_ELEM_SYNC = 0;
  localparam int EV_LAST_FRM  = 1;
  localparam int EV_HALF_FRM  = 2;
  localparam int EV_END_FRM   = 3;
  localparam int EV_FRM_SYNC  = 4;
  localparam int EV_PKT       = 5;
  localparam int EV_PKT_SYNC  = 6;
  localparam int EV_BLOCK     = 7;

endpackage

// File: rtl/dma_burst_dist.sv
module dma_burst_dist
  import dma_burst_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRM_W  = 8,
  parameter int PKT_W  = 8,
  parameter int DIST_W = CNT_W + FRM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  elem_len,
  input  logic [FRM_W-1:0]  frm_len,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic [CNT_W-1:0]  elem_pos,
  input  logic [FRM_W-1:0]  frm_pos,
  input  logic [PKT_W-1:0]  pkt_pos,
  input  logic              sync_en,
  input  logic              frame_mode,
  input  logic              packet_mode,
  input  logic              src_sync,
  input  logic              ie_last,
  input  logic              ie_half,
  input  logic              ie_frame,
  input  logic              ie_pkt,
  output logic [DIST_W-1:0] burst_n,
  output logic [NUM_EV-1:0] hit
);

  localparam int SW = DIST_W + 2;
  localparam logic signed [SW-1:0] S_ZERO = '0;
  localparam logic signed [SW-1:0] S_ONE  = SW'(1);
  localparam logic signed [SW-1:0] S_TWO  = SW'(2);
  localparam logic [DIST_W-1:0]    D_MAX  = '1;

  logic signed [SW-1:0] s_e, s_f, s_pl, s_ep, s_fp, s_pp;
  logic signed [SW-1:0] s_half, s_last, s_hdist, s_blk, s_frm_rem, s_pkt_rem;
  logic [DIST_W-1:0]    dv  [NUM_EV];
  logic [DIST_W-1:0]    sat [NUM_EV];
  logic [NUM_EV-1:0]    en;
  logic [DIST_W-1:0]    mn;

  // signed views of the unsigned counters and lengths
  always_comb begin
    s_e  = $signed({{(SW-CNT_W){1'b0}}, elem_len});
    s_f  = $signed({{(SW-FRM_W){1'b0}}, frm_len});
    s_pl = $signed({{(SW-PKT_W){1'b0}}, pkt_len});
    s_ep = $signed({{(SW-CNT_W){1'b0}}, elem_pos});
    s_fp = $signed({{(SW-FRM_W){1'b0}}, frm_pos});
    s_pp = $signed({{(SW-PKT_W){1'b0}}, pkt_pos});
  end

  // raw distances per condition
  always_comb begin
    s_frm_rem = s_e - s_ep;
    s_pkt_rem = s_pl - s_pp;
    s_half    = s_e >>> 1;
    s_hdist   = s_half + ((s_ep >= s_half) ? s_e : S_ZERO) - s_ep;
    s_last    = (s_f - s_fp - S_TWO) * s_e + (s_e - s_ep + S_ONE);
    s_blk     = (s_f - s_fp - S_ONE) * s_e + s_frm_rem;

    dv[EV_ELEM_SYNC] = DIST_W'(1);
    dv[EV_LAST_FRM]  = s_last[DIST_W-1:0];
    dv[EV_HALF_FRM]  = s_hdist[DIST_W-1:0];
    dv[EV_END_FRM]   = s_frm_rem[DIST_W-1:0];
    dv[EV_FRM_SYNC]  = s_frm_rem[DIST_W-1:0];
    dv[EV_PKT]       = s_pkt_rem[DIST_W-1:0];
    dv[EV_PKT_SYNC]  = s_pkt_rem[DIST_W-1:0];
    dv[EV_BLOCK]     = s_blk[DIST_W-1:0];

    en[EV_ELEM_SYNC] = sync_en && !frame_mode && !packet_mode;
    en[EV_LAST_FRM]  = ie_last && ((s_fp < s_f - S_ONE) || (elem_pos == '0));
    en[EV_HALF_FRM]  = ie_half;
    en[EV_END_FRM]   = sync_en && frame_mode && ie_frame;
    en[EV_FRM_SYNC]  = sync_en && frame_mode && !packet_mode;
    en[EV_PKT]       = frame_mode && packet_mode && ie_pkt && !src_sync;
    en[EV_PKT_SYNC]  = frame_mode && packet_mode && sync_en;
    en[EV_BLOCK]     = 1'b1;
  end

  // saturate disabled conditions, then take the minimum
  always_comb begin
    mn = D_MAX;
    for (int i = 0; i < NUM_EV; i++) begin
      sat[i] = en[i] ? dv[i] : D_MAX;
      if (sat[i] < mn) mn = sat[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_EV; g++) begin : g_hit
      assign hit[g] = en[g] && (dv[g] == mn);
    end
  endgenerate

  assign burst_n = mn;

  // R3: the chosen burst never passes the end of block and is never empty
  p_min_within_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (burst_n <= s_blk[DIST_W-1:0]) && (burst_n != '0));

  // R7: end of block fires whenever the burst reaches it
  p_block_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_len != '0 && burst_n == s_blk[DIST_W-1:0]) |-> hit[EV_BLOCK]);

endmodule

// File: rtl/dma_burst_adv.sv
module dma_burst_adv #(
  parameter int CNT_W  = 8,
  parameter int FRM_W  = 8,
  parameter int PKT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DIST_W = CNT_W + FRM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIST_W-1:0] burst_n,
  input  logic [CNT_W-1:0]  elem_len,
  input  logic [CNT_W-1:0]  elem_pos,
  input  logic [FRM_W-1:0]  frm_pos,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic [PKT_W-1:0]  pkt_pos,
  input  logic              pkt_active,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_edelta,
  input  logic [ADDR_W-1:0] src_fdelta,
  input  logic [ADDR_W-1:0] dst_edelta,
  input  logic [ADDR_W-1:0] dst_fdelta,
  output logic [CNT_W-1:0]  nxt_elem,
  output logic [FRM_W-1:0]  nxt_frm,
  output logic [PKT_W-1:0]  nxt_pkt,
  output logic [ADDR_W-1:0] nxt_src,
  output logic [ADDR_W-1:0] nxt_dst
);

  localparam int TW = DIST_W + 1;

  logic [TW-1:0]     tot, ediv, crossed, erem, ptot, pdiv, prem;
  logic [ADDR_W-1:0] n_a, c_a;

  always_comb begin
    tot     = TW'(elem_pos) + TW'(burst_n);
    ediv    = (elem_len == '0) ? TW'(1) : TW'(elem_len);
    crossed = tot / ediv;
    erem    = tot % ediv;
    ptot    = TW'(pkt_pos) + TW'(burst_n);
    pdiv    = (pkt_len == '0) ? TW'(1) : TW'(pkt_len);
    prem    = ptot % pdiv;

    nxt_elem = erem[CNT_W-1:0];
    nxt_frm  = frm_pos + crossed[FRM_W-1:0];
    nxt_pkt  = pkt_active ? prem[PKT_W-1:0] : pkt_pos;

    n_a     = ADDR_W'(burst_n);
    c_a     = ADDR_W'(crossed);
    nxt_src = src_addr + n_a * src_edelta + c_a * src_fdelta;
    nxt_dst = dst_addr + n_a * dst_edelta + c_a * dst_fdelta;
  end

  // R8: the element counter always lands inside a frame
  p_elem_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && elem_len != '0) |-> (nxt_elem < elem_len));

  // R8: outside packet mode the packet counter is left alone
  p_pkt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pkt_active) |-> (nxt_pkt == pkt_pos));

endmodule

// File: rtl/dma_burst_class.sv
module dma_burst_class
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FRM_W  = 8
) (
  input  logic [ADDR_W-1:0] edelta,
  input  logic [ADDR_W-1:0] fdelta,
  input  logic [2:0]        elem_size,
  input  logic [FRM_W-1:0]  frm_len,
  input  logic              fill_en,
  input  logic              xpar_en,
  input  logic              endian_mis,
  output acc_class_e        acc
);

  logic plain, flat;

  always_comb begin
    plain = !fill_en && !xpar_en && !endian_mis;
    flat  = (frm_len == FRM_W'(1)) || (fdelta == '0);
    if (plain && flat && edelta == '0)
      acc = ACC_CONST;
    else if (plain && flat && edelta == ADDR_W'(elem_size))
      acc = ACC_LINEAR;
    else
      acc = ACC_OTHER;
  end

endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
  import dma_burst_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRM_W  = 8,
  parameter int PKT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DIST_W = CNT_W + FRM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  elem_len,
  input  logic [FRM_W-1:0]  frm_len,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic [CNT_W-1:0]  elem_pos,
  input  logic [FRM_W-1:0]  frm_pos,
  input  logic [PKT_W-1:0]  pkt_pos,
  input  logic              sync_en,
  input  logic              frame_mode,
  input  logic              packet_mode,
  input  logic              src_sync,
  input  logic              ie_last,
  input  logic              ie_half,
  input  logic              ie_frame,
  input  logic              ie_pkt,
  input  logic [2:0]        elem_size,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_edelta,
  input  logic [ADDR_W-1:0] src_fdelta,
  input  logic [ADDR_W-1:0] dst_edelta,
  input  logic [ADDR_W-1:0] dst_fdelta,
  input  logic              fill_en,
  input  logic              xpar_en,
  input  logic              endian_mis,
  output logic              done,
  output logic [DIST_W-1:0] burst_elems,
  output logic [DIST_W+2:0] burst_bytes,
  output logic [7:0]        events,
  output logic [CNT_W-1:0]  next_elem,
  output logic [FRM_W-1:0]  next_frame,
  output logic [PKT_W-1:0]  next_pkt,
  output logic [ADDR_W-1:0] next_src,
  output logic [ADDR_W-1:0] next_dst,
  output logic [1:0]        src_class,
  output logic [1:0]        dst_class
);

  localparam int BW = DIST_W + 3;

  logic [DIST_W-1:0] c_burst;
  logic [NUM_EV-1:0] c_hit;
  logic [CNT_W-1:0]  c_elem;
  logic [FRM_W-1:0]  c_frm;
  logic [PKT_W-1:0]  c_pkt;
  logic [ADDR_W-1:0] c_src, c_dst;
  acc_class_e        c_cls [2];

  logic [ADDR_W-1:0] side_ed [2];
  logic [ADDR_W-1:0] side_fd [2];

  // next-state values
  logic              d_done;
  logic [DIST_W-1:0] d_burst;
  logic [BW-1:0]     d_bytes;
  logic [7:0]        d_ev;
  logic [CNT_W-1:0]  d_elem;
  logic [FRM_W-1:0]  d_frm;
  logic [PKT_W-1:0]  d_pkt;
  logic [ADDR_W-1:0] d_src, d_dst;
  logic [1:0]        d_scls, d_dcls;

  dma_burst_dist #(
    .CNT_W(CNT_W), .FRM_W(FRM_W), .PKT_W(PKT_W), .DIST_W(DIST_W)
  ) u_dist (
    .clk(clk), .rst_n(rst_n), .start(start),
    .elem_len(elem_len), .frm_len(frm_len), .pkt_len(pkt_len),
    .elem_pos(elem_pos), .frm_pos(frm_pos), .pkt_pos(pkt_pos),
    .sync_en(sync_en), .frame_mode(frame_mode), .packet_mode(packet_mode),
    .src_sync(src_sync), .ie_last(ie_last), .ie_half(ie_half),
    .ie_frame(ie_frame), .ie_pkt(ie_pkt),
    .burst_n(c_burst), .hit(c_hit)
  );

  dma_burst_adv #(
    .CNT_W(CNT_W), .FRM_W(FRM_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W), .DIST_W(DIST_W)
  ) u_adv (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_n(c_burst),
    .elem_len(elem_len), .elem_pos(elem_pos), .frm_pos(frm_pos),
    .pkt_len(pkt_len), .pkt_pos(pkt_pos),
    .pkt_active(frame_mode && packet_mode),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_edelta(src_edelta), .src_fdelta(src_fdelta),
    .dst_edelta(dst_edelta), .dst_fdelta(dst_fdelta),
    .nxt_elem(c_elem), .nxt_frm(c_frm), .nxt_pkt(c_pkt),
    .nxt_src(c_src), .nxt_dst(c_dst)
  );

  assign side_ed[0] = src_edelta;
  assign side_ed[1] = dst_edelta;
  assign side_fd[0] = src_fdelta;
  assign side_fd[1] = dst_fdelta;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      dma_burst_class #(.ADDR_W(ADDR_W), .FRM_W(FRM_W)) u_cls (
        .edelta(side_ed[s]), .fdelta(side_fd[s]), .elem_size(elem_size),
        .frm_len(frm_len), .fill_en(fill_en), .xpar_en(xpar_en),
        .endian_mis(endian_mis), .acc(c_cls[s])
      );
    end
  endgenerate

  // clock-enabled next state
  always_comb begin
    d_done  = start;
    d_burst = burst_elems;
    d_bytes = burst_bytes;
    d_ev    = events;
    d_elem  = next_elem;
    d_frm   = next_frame;
    d_pkt   = next_pkt;
    d_src   = next_src;
    d_dst   = next_dst;
    d_scls  = src_class;
    d_dcls  = dst_class;
    if (start) begin
      d_burst = c_burst;
      d_bytes = BW'(c_burst) * BW'(elem_size);
      d_ev    = c_hit;
      d_elem  = c_elem;
      d_frm   = c_frm;
      d_pkt   = c_pkt;
      d_src   = c_src;
      d_dst   = c_dst;
      d_scls  = c_cls[0];
      d_dcls  = c_cls[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      burst_elems <= '0;
      burst_bytes <= '0;
      events      <= '0;
      next_elem   <= '0;
      next_frame  <= '0;
      next_pkt    <= '0;
      next_src    <= '0;
      next_dst    <= '0;
      src_class   <= '0;
      dst_class   <= '0;
    end else begin
      done        <= d_done;
      burst_elems <= d_burst;
      burst_bytes <= d_bytes;
      events      <= d_ev;
      next_elem   <= d_elem;
      next_frame  <= d_frm;
      next_pkt    <= d_pkt;
      next_src    <= d_src;
      next_dst    <= d_dst;
      src_class   <= d_scls;
      dst_class   <= d_dcls;
    end
  end

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R4: element-synchronised channels move a single element
  p_elem_sync_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sync_en && !frame_mode && !packet_mode) |=> (burst_elems == DIST_W'(1)));

  // R7: end of block is always enabled, so some condition is always reported
  p_some_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (events != '0));

endmodule

// File: tb/dma_burst_calc_bench.sv
module dma_burst_calc_bench;

  localparam int CNT_W  = 8;
  localparam int FRM_W  = 8;
  localparam int PKT_W  = 8;
  localparam int ADDR_W = 16;
  localparam int DIST_W = CNT_W + FRM_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] elem_len = '0, elem_pos = '0;
  logic [FRM_W-1:0] frm_len = '0, frm_pos = '0;
  logic [PKT_W-1:0] pkt_len = '0, pkt_pos = '0;
  logic sync_en = 0, frame_mode = 0, packet_mode = 0, src_sync = 0;
  logic ie_last = 0, ie_half = 0, ie_frame = 0, ie_pkt = 0;
  logic [2:0] elem_size = 3'd1;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0;
  logic [ADDR_W-1:0] src_edelta = '0, src_fdelta = '0, dst_edelta = '0, dst_fdelta = '0;
  logic fill_en = 0, xpar_en = 0, endian_mis = 0;

  logic              done;
  logic [DIST_W-1:0] burst_elems;
  logic [DIST_W+2:0] burst_bytes;
  logic [7:0]        events;
  logic [CNT_W-1:0]  next_elem;
  logic [FRM_W-1:0]  next_frame;
  logic [PKT_W-1:0]  next_pkt;
  logic [ADDR_W-1:0] next_src, next_dst;
  logic [1:0]        src_class, dst_class;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_burst_calc #(.CNT_W(CNT_W), .FRM_W(FRM_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W))
  u_dma_burst_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .elem_len(elem_len), .frm_len(frm_len), .pkt_len(pkt_len),
    .elem_pos(elem_pos), .frm_pos(frm_pos), .pkt_pos(pkt_pos),
    .sync_en(sync_en), .frame_mode(frame_mode), .packet_mode(packet_mode),
    .src_sync(src_sync), .ie_last(ie_last), .ie_half(ie_half),
    .ie_frame(ie_frame), .ie_pkt(ie_pkt), .elem_size(elem_size),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .src_edelta(src_edelta), .src_fdelta(src_fdelta),
    .dst_edelta(dst_edelta), .dst_fdelta(dst_fdelta),
    .fill_en(fill_en), .xpar_en(xpar_en), .endian_mis(endian_mis),
    .done(done), .burst_elems(burst_elems), .burst_bytes(burst_bytes),
    .events(events), .next_elem(next_elem), .next_frame(next_frame),
    .next_pkt(next_pkt), .next_src(next_src), .next_dst(next_dst),
    .src_class(src_class), .dst_class(dst_class)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  // expected-value model
  int x_n, x_ev, x_elem, x_frm, x_pkt, x_src, x_dst;

  task automatic model(input int e_l, input int f_l, input int p_l,
                       input int e, input int f, input int p,
                       input bit sy, input bit fs, input bit bs, input bit ss,
                       input bit il, input bit ih, input bit ifr, input bit ip,
                       input int sa, input int sed, input int sfd,
                       input int da, input int ded, input int dfd);
    int d [8];
    bit en [8];
    int t, c;
    en[0] = sy && !fs && !bs;               d[0] = 1;                              // R4
    en[1] = il && ((f < f_l - 1) || e == 0); d[1] = (f_l - f - 2) * e_l + (e_l - e + 1); // R5
    en[2] = ih;                              d[2] = e_l / 2 + ((e >= e_l / 2) ? e_l : 0) - e; // R5
    en[3] = sy && fs && ifr;                 d[3] = e_l - e;                        // R4
    en[4] = sy && fs && !bs;                 d[4] = e_l - e;                        // R4
    en[5] = fs && bs && ip && !ss;           d[5] = p_l - p;                        // R6
    en[6] = fs && bs && sy;                  d[6] = p_l - p;                        // R6
    en[7] = 1'b1;                            d[7] = (f_l - f - 1) * e_l + (e_l - e); // R3
    x_n = 1 << 30;
    for (int i = 0; i < 8; i++) if (en[i] && d[i] < x_n) x_n = d[i];
    x_ev = 0;
    for (int i = 0; i < 8; i++) if (en[i] && d[i] == x_n) x_ev |= (1 << i);
    t = e + x_n;
    c = t / e_l;
    x_elem = t % e_l;
    x_frm = f + c;
    x_pkt = (fs && bs) ? (p + x_n) % p_l : p;
    x_src = (sa + x_n * sed + c * sfd) & 32'hFFFF;
    x_dst = (da + x_n * ded + c * dfd) & 32'hFFFF;
  endtask

  initial begin
    int sizes [3];
    int vec;
    sizes[0] = 1; sizes[1] = 2; sizes[2] = 4;
    vec = 0;

    repeat (3) @(negedge clk);
    // R1: reset values
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(burst_elems == '0 && burst_bytes == '0, "R1 burst in reset", burst_elems, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(events == '0, "R1 events after reset", events, 0);

    // main sweep
    src_addr   = 16'd100;  src_edelta = 16'd2; src_fdelta = 16'hFFFD;
    dst_addr   = 16'hFFF0; dst_edelta = 16'd4; dst_fdelta = 16'd7;
    pkt_len    = 8'd3;
    for (int el = 1; el <= 5; el++) begin
      for (int fl = 1; fl <= 3; fl++) begin
        for (int fp = 0; fp < fl; fp++) begin
          for (int ep = 0; ep < el; ep++) begin
            for (int m = 0; m < 256; m++) begin
              int pp, sz;
              pp = (ep + fp + m) % 3;
              sz = sizes[vec % 3];
              vec++;
              elem_len = CNT_W'(el); frm_len = FRM_W'(fl);
              elem_pos = CNT_W'(ep); frm_pos = FRM_W'(fp); pkt_pos = PKT_W'(pp);
              {sync_en, frame_mode, packet_mode, src_sync} = 4'(m >> 4);
              {ie_last, ie_half, ie_frame, ie_pkt} = 4'(m);
              elem_size = 3'(sz);
              model(el, fl, 3, ep, fp, pp, sync_en, frame_mode, packet_mode, src_sync,
                    ie_last, ie_half, ie_frame, ie_pkt,
                    100, 2, -3, 16'hFFF0, 4, 7);
              start = 1'b1;
              @(negedge clk);
              start = 1'b0;
              check(done == 1'b1, "R2 done after start", done, 1);
              check(int'(burst_elems) == x_n, "R3 burst length (R4 R5 R6 distances)", burst_elems, x_n);
              check(int'(events) == x_ev, "R7 coinciding events", events, x_ev);
              check(int'(next_elem) == x_elem && int'(next_frame) == x_frm,
                    "R8 element/frame advance", {next_frame, next_elem}, (x_frm << CNT_W) | x_elem);
              check(int'(next_pkt) == x_pkt, "R8 packet advance", next_pkt, x_pkt);
              check(int'(next_src) == x_src && int'(next_dst) == x_dst,
                    "R9 address advance", {next_src, next_dst}, (longint'(x_src) << 16) | x_dst);
              check(int'(burst_bytes) == x_n * sz, "R10 burst bytes", burst_bytes, x_n * sz);
              if (vec % 97 == 0) begin
                @(negedge clk);
                check(done == 1'b0, "R2 done single cycle", done, 0);
                check(int'(burst_elems) == x_n, "R2 results hold", burst_elems, x_n);
              end
            end
          end
        end
      end
    end

    // access class sweep (R11)
    for (int dsel = 0; dsel < 4; dsel++) begin
      for (int ssel = 0; ssel < 3; ssel++) begin
        for (int fl = 1; fl <= 2; fl++) begin
          for (int fd = 0; fd < 2; fd++) begin
            for (int fl3 = 0; fl3 < 8; fl3++) begin
              int dv, sz, exp_s, exp_d;
              bit plain, flat_s;
              dv = (dsel == 0) ? 0 : (dsel == 1) ? 1 : (dsel == 2) ? 2 : 4;
              sz = sizes[ssel];
              src_edelta = ADDR_W'(dv);
              src_fdelta = ADDR_W'(fd * 5);
              dst_edelta = ADDR_W'(sz);
              dst_fdelta = '0;
              elem_size = 3'(sz);
              frm_len = FRM_W'(fl);
              elem_len = 8'd2; elem_pos = '0; frm_pos = '0; pkt_pos = '0;
              {fill_en, xpar_en, endian_mis} = 3'(fl3);
              plain  = (fl3 == 0);
              flat_s = (fl == 1) || (fd == 0);
              exp_s = (plain && flat_s && dv == 0) ? 0 :
                      (plain && flat_s && dv == sz) ? 1 : 2;
              exp_d = plain ? 1 : 2;
              start = 1'b1;
              @(negedge clk);
              start = 1'b0;
              check(int'(src_class) == exp_s, "R11 source class", src_class, exp_s);
              check(int'(dst_class) == exp_d, "R11 destination class", dst_class, exp_d);
            end
          end
        end
      end
    end

    finish_run();
  end

endmodule